// File: doc/BRIEF.md
# Single-Step Trace Trap Controller

This block adds instruction-by-instruction tracing to a four-stage in-order pipeline (fetch, decode, execute, write-back). It owns the live processor status register, which holds a trace-enable flag and a trap-pending flag among other software-visible bits. The trap is not raised by the enable flag directly. Instead, each time an instruction crosses from execute into write-back, the enable flag is copied into the pending flag. A pending flag then produces a trace trap, so each trap is armed by one specific retiring instruction.

On trap entry the controller copies the whole live register into a saved-status register. It then clears both trace flags in the live register, so the handler runs untraced. It also raises a registered trap request, a vector select, and a flush for the three stages ahead of write-back. The instruction already in write-back completes. A trap-return strobe copies the saved status back in one cycle, with the pending flag dropped so the same instruction does not trap again. With tracing left on, exactly one instruction executes between consecutive trace traps.

Top module: `trace_trap_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the live status, the saved status, the trap request, the flush vector and the vector select to zero.
- R2: When `ex_valid` and `ex_adv` are both high (a retire), the next live status has its trap-pending bit (bit 1 by default) equal to the trace-enable bit (bit 0 by default) from before the edge.
- R3: In a cycle with no retire, no trap entry and no trap return, the trap-pending bit keeps its value.
- R4: A set trap-pending bit causes trap entry at the next edge. `trap_req` is then high for exactly one cycle, with `flush` all ones and `vec_sel` equal to `TRACE_VEC`. `flush` bit 0 is fetch, bit 1 is decode and bit 2 is execute. All three outputs are zero in every other cycle.
- R5: On trap entry the saved status takes the full live status from before the edge. The live status clears trace-enable and trap-pending and keeps all other bits.
- R6: When `trap_ret` is high, the live status is loaded from the saved status in one cycle, with the trap-pending bit forced to zero.
- R7: A software write replaces every live bit except trap-pending. The written trap-pending bit is ignored. If a retire happens in the same cycle, trace-enable takes the written value and trap-pending takes the trace-enable value from before the write.
- R8: Trap entry has priority over a trap return and over a software write in the same cycle. Trap return has priority over a software write.
- R9: With trace-enable kept on and the handler returning after each trap, every retiring instruction produces exactly one trace trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_adv | input | 1 | Execute stage advances into write-back this cycle |
| sr_wr_en | input | 1 | Software write strobe for the live status |
| sr_wr_data | input | STAT_W | Software write value |
| trap_ret | input | 1 | Return-from-trap strobe |
| trap_req | output | 1 | Registered trace trap request, one-cycle pulse |
| flush | output | 3 | Flush for fetch (bit 0), decode (bit 1) and execute (bit 2) |
| vec_sel | output | VEC_W | Trap vector select, `TRACE_VEC` during a request |
| status_q | output | STAT_W | Live processor status |
| saved_q | output | STAT_W | Saved status captured on trap entry |

## Verification
The assertions assume the surrounding pipeline holds the execute stage while the trap-pending bit is set. No instruction retires in the cycle the trap is taken, which keeps the one-instruction-per-trap rule intact. They also assume `ex_adv` is asserted only together with `ex_valid`. The stimulus honours both rules. It never retires in a cycle where the reference model shows a pending trap, and it drives the advance strobe only with a valid instruction. Within those limits it also drives software writes and return strobes into the trap-entry cycle to exercise the priority order.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int NUM_STAGES  = 4;
  localparam int STG_FETCH   = 0;
  localparam int STG_DECODE  = 1;
  localparam int STG_EXECUTE = 2;
  localparam int STG_WRBACK  = 3;
  // stages ahead of write-back are the ones a trap discards
  localparam int FLUSH_W     = STG_WRBACK;

  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_TAKE  = 2'd1,
    SR_RET   = 2'd2,
    SR_WRITE = 2'd3
  } sr_src_e;
endpackage

// File: rtl/trace_status_reg.sv
module trace_status_reg
  import trace_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int TE_BIT = 0,
  parameter int TP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              ret,
  input  logic [STAT_W-1:0] saved_in,
  output logic              take,
  output logic [STAT_W-1:0] stat_q
);
  sr_src_e           src;
  logic [STAT_W-1:0] nxt;

  assign take = stat_q[TP_BIT];

  always_comb begin
    if (take)       src = SR_TAKE;
    else if (ret)   src = SR_RET;
    else if (wr_en) src = SR_WRITE;
    else            src = SR_HOLD;
  end

  always_comb begin
    nxt = stat_q;
    case (src)
      SR_TAKE: begin
        nxt[TE_BIT] = 1'b0;
        nxt[TP_BIT] = 1'b0;
      end
      SR_RET: begin
        nxt         = saved_in;
        nxt[TP_BIT] = 1'b0;
      end
      SR_WRITE: begin
        nxt         = wr_data;
        nxt[TP_BIT] = retire ? stat_q[TE_BIT] : stat_q[TP_BIT];
      end
      default: begin
        if (retire) nxt[TP_BIT] = stat_q[TE_BIT];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= nxt;
  end

  // R2
  tp_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (retire && !take && !ret) |=> (stat_q[TP_BIT] == $past(stat_q[TE_BIT])));
  // R3
  tp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!retire && !take && !ret) |=> $stable(stat_q[TP_BIT]));
  // R5
  flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!stat_q[TE_BIT] && !stat_q[TP_BIT]));
  // R6
  ret_tp_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && !take) |=> !stat_q[TP_BIT]);
  // R7
  wr_te_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ret && !take) |=> (stat_q[TE_BIT] == $past(wr_data[TE_BIT])));
endmodule

// File: rtl/trace_save_reg.sv
module trace_save_reg #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [STAT_W-1:0] stat_in,
  output logic [STAT_W-1:0] saved_q
);
  always_ff @(posedge clk) begin
    if (rst)       saved_q <= '0;
    else if (take) saved_q <= stat_in;
  end

  // R5
  save_cap_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (saved_q == $past(stat_in)));
  // R5
  save_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(saved_q));
endmodule

// File: rtl/trace_trap_seq.sv
module trace_trap_seq #(
  parameter int             FLUSH_W   = 3,
  parameter int             VEC_W     = 8,
  parameter logic [VEC_W-1:0] TRACE_VEC = 8'h06
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  output logic               trap_req,
  output logic [FLUSH_W-1:0] flush,
  output logic [VEC_W-1:0]   vec_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      vec_sel  <= '0;
    end else begin
      trap_req <= take;
      vec_sel  <= take ? TRACE_VEC : '0;
    end
  end

  for (genvar g = 0; g < FLUSH_W; g++) begin : g_flush
    always_ff @(posedge clk) begin
      if (rst) flush[g] <= 1'b0;
      else     flush[g] <= take;
    end
  end

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> !trap_req);
  // R4
  req_flush_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (&flush && vec_sel == TRACE_VEC));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_req |-> (flush == '0 && vec_sel == '0));
endmodule

// File: rtl/trace_trap_ctrl.sv
module trace_trap_ctrl
  import trace_pkg::*;
#(
  parameter int               STAT_W    = 8,
  parameter int               TE_BIT    = 0,
  parameter int               TP_BIT    = 1,
  parameter int               VEC_W     = 8,
  parameter logic [VEC_W-1:0] TRACE_VEC = 8'h06
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ex_valid,
  input  logic               ex_adv,
  input  logic               sr_wr_en,
  input  logic [STAT_W-1:0]  sr_wr_data,
  input  logic               trap_ret,
  output logic               trap_req,
  output logic [FLUSH_W-1:0] flush,
  output logic [VEC_W-1:0]   vec_sel,
  output logic [STAT_W-1:0]  status_q,
  output logic [STAT_W-1:0]  saved_q
);
  logic retire;
  logic take;

  assign retire = ex_valid & ex_adv;

  trace_status_reg #(
    .STAT_W (STAT_W),
    .TE_BIT (TE_BIT),
    .TP_BIT (TP_BIT)
  ) u_status (
    .clk      (clk),
    .rst      (rst),
    .retire   (retire),
    .wr_en    (sr_wr_en),
    .wr_data  (sr_wr_data),
    .ret      (trap_ret),
    .saved_in (saved_q),
    .take     (take),
    .stat_q   (status_q)
  );

  trace_save_reg #(
    .STAT_W (STAT_W)
  ) u_save (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .stat_in (status_q),
    .saved_q (saved_q)
  );

  trace_trap_seq #(
    .FLUSH_W   (FLUSH_W),
    .VEC_W     (VEC_W),
    .TRACE_VEC (TRACE_VEC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .trap_req (trap_req),
    .flush    (flush),
    .vec_sel  (vec_sel)
  );

  // R9: input contract, execute stage is held while a trap is pending
  hold_on_pending_chk: assert property (@(posedge clk) disable iff (rst)
    status_q[TP_BIT] |-> !retire);
  // R9: input contract, advance only with a valid instruction
  adv_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ex_adv |-> ex_valid);
  // R4
  entry_req_chk: assert property (@(posedge clk) disable iff (rst)
    status_q[TP_BIT] |=> trap_req);
  // R8
  entry_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q[TP_BIT] && (trap_ret || sr_wr_en)) |=>
      (saved_q == $past(status_q) && !status_q[TE_BIT]));
  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (status_q == '0 && saved_q == '0 && !trap_req));
endmodule

// File: tb/test_trace_trap_ctrl.sv
module test_trace_trap_ctrl;
  localparam int         STAT_W = 8;
  localparam int         TE     = 0;
  localparam int         TP     = 1;
  localparam logic [7:0] VEC    = 8'h06;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ex_valid = 1'b0, ex_adv = 1'b0;
  logic              sr_wr_en = 1'b0, trap_ret = 1'b0;
  logic [STAT_W-1:0] sr_wr_data = '0;
  logic              trap_req;
  logic [2:0]        flush;
  logic [7:0]        vec_sel;
  logic [STAT_W-1:0] status_q, saved_q;

  int errors = 0, checks = 0, cycles = 0, traps = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  logic [STAT_W-1:0] m_stat = '0, m_saved = '0;
  logic              m_req = 1'b0;

  always #5 clk = ~clk;

  trace_trap_ctrl i_trace_trap_ctrl (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_adv(ex_adv),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .trap_ret(trap_ret),
    .trap_req(trap_req), .flush(flush), .vec_sel(vec_sel),
    .status_q(status_q), .saved_q(saved_q));

  always @(posedge clk) begin
    logic old_te;
    logic [STAT_W-1:0] tmp;
    if (rst) begin
      m_stat = '0; m_saved = '0; m_req = 1'b0;
    end else begin
      old_te = m_stat[TE];
      if (m_stat[TP]) begin
        m_req = 1'b1;
        m_saved = m_stat;
        m_stat[TE] = 1'b0;
        m_stat[TP] = 1'b0;
      end else begin
        m_req = 1'b0;
        if (trap_ret) begin
          m_stat = m_saved;
          m_stat[TP] = 1'b0;
        end else begin
          if (sr_wr_en) begin
            tmp = sr_wr_data;
            tmp[TP] = m_stat[TP];
            m_stat = tmp;
          end
          if (ex_valid && ex_adv) m_stat[TP] = old_te;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "status", status_q, m_stat);
      chk(cur_req, "saved", saved_q, m_saved);
      chk(cur_req, "trap_req", trap_req, m_req);
      chk(cur_req, "flush", flush, m_req ? 3'b111 : 3'b000);
      chk(cur_req, "vec_sel", vec_sel, m_req ? VEC : 8'h00);
      if (trap_req) traps++;
    end
  end

  task automatic step(bit ret, bit rtr, bit wr, logic [7:0] d);
    trap_ret = ret; ex_valid = rtr; ex_adv = rtr;
    sr_wr_en = wr; sr_wr_data = d;
    @(negedge clk);
    trap_ret = 0; ex_valid = 0; ex_adv = 0; sr_wr_en = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "status", status_q, 0);
    chk("R1", "saved", saved_q, 0);
    chk("R1", "trap_req", trap_req, 0);
    chk("R1", "flush", flush, 0);
    chk("R1", "vec_sel", vec_sel, 0);

    cur_req = "R2";
    step(0, 1, 0, 0);
    chk("R2", "status no trace", status_q, 8'h00);

    cur_req = "R7";
    step(0, 0, 1, 8'h83);
    chk("R7", "written TP ignored", status_q, 8'h81);

    cur_req = "R3";
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R3", "TP held over bubbles", status_q, 8'h81);

    cur_req = "R2";
    step(0, 1, 0, 0);
    chk("R2", "TP armed", status_q, 8'h83);

    cur_req = "R4";
    step(0, 0, 0, 0);
    chk("R4", "trap_req", trap_req, 1);
    chk("R4", "flush", flush, 3'b111);
    chk("R4", "vec_sel", vec_sel, VEC);
    chk("R5", "saved", saved_q, 8'h83);
    chk("R5", "status cleared", status_q, 8'h80);
    step(0, 0, 0, 0);
    chk("R4", "one-cycle pulse", trap_req, 0);

    cur_req = "R2";
    step(0, 1, 0, 0);
    chk("R2", "handler untraced", status_q, 8'h80);

    cur_req = "R6";
    step(1, 0, 0, 0);
    chk("R6", "restore", status_q, 8'h81);

    cur_req = "R9";
    traps = 0;
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, 0);
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      step(1, 0, 0, 0);
    end
    chk("R9", "one trap per instruction", traps, 3);

    cur_req = "R7";
    step(0, 1, 1, 8'h80);
    chk("R7", "TE from write, TP from old TE", status_q, 8'h82);
    step(0, 0, 0, 0);
    chk("R7", "trap after write", trap_req, 1);
    chk("R7", "saved", saved_q, 8'h82);
    step(1, 0, 0, 0);
    chk("R6", "restore TE off", status_q, 8'h80);

    cur_req = "R8";
    step(0, 0, 1, 8'h01);
    step(0, 1, 0, 0);
    chk("R8", "armed", status_q, 8'h03);
    step(1, 0, 1, 8'h40);
    chk("R8", "entry beats return and write", status_q, 8'h00);
    chk("R8", "saved", saved_q, 8'h03);
    chk("R8", "trap_req", trap_req, 1);
    step(1, 0, 1, 8'h40);
    chk("R8", "return beats write", status_q, 8'h01);
    step(0, 0, 0, 0);
    finish_run();
  end
endmodule